// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs next to a simple processor core. It owns the program counter, the stack pointer and the processor status word, and it takes over from the core for a few cycles when an interrupt is entered or left. All external request lines are OR-ed into one pending condition. That condition is accepted only when the interrupt-enable bit of the status word is set and the core reports that an instruction has just finished.

On entry the sequencer saves the return address and the status word on a descending memory stack, one write per cycle. It then clears the enable bit, raises a one-cycle acknowledge and loads the fixed handler address into the PC. On a return request at an instruction boundary, it reads the status word back first and the PC second, raising SP after each read. Because the saved status word had the enable bit set, the restore turns interrupts back on. While either sequence runs, `busy` is high so the core stalls fetch, and the core's own writes to PC and status are dropped.

Top module: `irq_seq`

## Requirements
- R1: After reset, PC equals PC_RESET, SP equals SP_INIT, the status word is zero (enable bit at position IE_BIT = 0 clear), and `busy`, `irq_ack`, `mem_we` and `mem_re` are low.
- R2: A request on any single line of `irq_req` is enough to start entry. With all lines low and no return request, the block stays idle.
- R3: Entry starts only in a cycle where `instr_done` is high and the enable bit is set. Otherwise `busy` stays low.
- R4: Entry writes the PC to address SP-1 and then the status word to address SP-2, in that order, and leaves SP at SP-2.
- R5: In the last entry cycle `irq_ack` is high for exactly one cycle. Afterwards the enable bit is clear, the other status bits are unchanged, and PC equals VECTOR.
- R6: `busy` is high for exactly 5 consecutive cycles on entry and exactly 4 on return, starting the cycle after the accepting edge.
- R7: Return (`reti_req` with `instr_done`) reads the status word from SP and then the PC from SP+1, using a one-cycle-latency read port. It leaves SP raised by 2 and restores both values, re-enabling interrupts.
- R8: A request held while the enable bit is clear is ignored until the bit is set. It is then serviced at the next instruction boundary.
- R9: While `busy` is high, `core_pc_we` and `psr_we` have no effect on PC or the status word.
- R10: If a return request and an eligible interrupt arrive in the same boundary cycle, the return is performed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_REQ | External interrupt request lines |
| instr_done | input | 1 | Core has just completed an instruction |
| reti_req | input | 1 | Current instruction is a return-from-interrupt |
| core_pc_we | input | 1 | Core load of the PC |
| core_pc_d | input | W | New PC value from the core |
| psr_we | input | 1 | Core write of the status word |
| psr_d | input | W | New status word from the core |
| mem_rdata | input | W | Stack read data, valid the cycle after `mem_re` |
| busy | output | 1 | Sequence in progress; core must stall |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| pc_q | output | W | Program counter |
| sp_q | output | W | Stack pointer |
| psr_q | output | W | Processor status word |
| mem_addr | output | W | Stack memory address |
| mem_wdata | output | W | Stack memory write data |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |

## Verification
The assertions assume a memory that returns read data exactly one cycle after `mem_re`. They also assume the core raises `reti_req` only inside a handler, so that returns never outnumber entries. The bench memory model is built with that one-cycle latency, and every random trial pairs each entry with one later return. The random part varies the PC, the status word, the request line and the stray core writes issued during a sequence. Directed cases cover a boundary cycle without `instr_done`, a request waiting for the enable bit, and a return that collides with a new request.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_DEC1,
    ST_E_PC,
    ST_E_DEC2,
    ST_E_PSR,
    ST_E_FIN,
    ST_R_RD_PSR,
    ST_R_WB_PSR,
    ST_R_RD_PC,
    ST_R_WB_PC
  } seq_state_t;

  function automatic logic [15:0] stack_down(input logic [15:0] sp);
    return sp - 16'd1;
  endfunction

  function automatic logic [15:0] stack_up(input logic [15:0] sp);
    return sp + 16'd1;
  endfunction

  function automatic logic [15:0] drop_bit(input logic [15:0] v, input int unsigned pos);
    logic [15:0] m;
    m = 16'd1 << pos;
    return v & ~m;
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] irq_req,
  input  logic             ie,
  input  logic             instr_done,
  input  logic             reti_req,
  input  logic             idle,
  output logic             start_irq,
  output logic             start_ret
);
  logic pending;

  assign pending   = |irq_req;
  assign start_ret = idle && instr_done && reti_req;
  assign start_irq = idle && instr_done && ie && pending && !reti_req;
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_irq,
  input  logic start_ret,
  output logic idle,
  output logic sp_dec,
  output logic push_pc,
  output logic push_psr,
  output logic fin,
  output logic pop_rd,
  output logic pop_psr_wb,
  output logic pop_pc_wb
);
  seq_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:     if (start_ret) st_nx = ST_R_RD_PSR;
                   else if (start_irq) st_nx = ST_E_DEC1;
      ST_E_DEC1:   st_nx = ST_E_PC;
      ST_E_PC:     st_nx = ST_E_DEC2;
      ST_E_DEC2:   st_nx = ST_E_PSR;
      ST_E_PSR:    st_nx = ST_E_FIN;
      ST_E_FIN:    st_nx = ST_IDLE;
      ST_R_RD_PSR: st_nx = ST_R_WB_PSR;
      ST_R_WB_PSR: st_nx = ST_R_RD_PC;
      ST_R_RD_PC:  st_nx = ST_R_WB_PC;
      ST_R_WB_PC:  st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign idle       = (st == ST_IDLE);
  assign sp_dec     = (st == ST_E_DEC1) || (st == ST_E_DEC2);
  assign push_pc    = (st == ST_E_PC);
  assign push_psr   = (st == ST_E_PSR);
  assign fin        = (st == ST_E_FIN);
  assign pop_rd     = (st == ST_R_RD_PSR) || (st == ST_R_RD_PC);
  assign pop_psr_wb = (st == ST_R_WB_PSR);
  assign pop_pc_wb  = (st == ST_R_WB_PC);

  // R5: acknowledge never lasts two cycles
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  // R4: PSR is pushed two cycles after the PC
  a_r4_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |=> !push_psr);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_seq_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          IE_BIT   = 0,
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_INIT  = 16'h0080,
  parameter logic [15:0] VECTOR   = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle,
  input  logic         sp_dec,
  input  logic         push_pc,
  input  logic         push_psr,
  input  logic         fin,
  input  logic         pop_rd,
  input  logic         pop_psr_wb,
  input  logic         pop_pc_wb,
  input  logic         core_pc_we,
  input  logic [W-1:0] core_pc_d,
  input  logic         psr_we,
  input  logic [W-1:0] psr_d,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] psr_q,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         mem_re
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= PC_RESET;
      sp_q  <= SP_INIT;
      psr_q <= '0;
    end else begin
      if (sp_dec)                    sp_q <= stack_down(sp_q);
      else if (pop_psr_wb || pop_pc_wb) sp_q <= stack_up(sp_q);

      if (fin)                       pc_q <= VECTOR;
      else if (pop_pc_wb)            pc_q <= mem_rdata;
      else if (idle && core_pc_we)   pc_q <= core_pc_d;

      if (fin)                       psr_q <= drop_bit(psr_q, IE_BIT);
      else if (pop_psr_wb)           psr_q <= mem_rdata;
      else if (idle && psr_we)       psr_q <= psr_d;
    end
  end

  assign mem_addr  = sp_q;
  assign mem_we    = push_pc || push_psr;
  assign mem_wdata = push_pc ? pc_q : psr_q;
  assign mem_re    = pop_rd;

  // R5: enable bit is clear right after the acknowledge cycle
  a_r5_ie_off_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !psr_q[IE_BIT]);
  // R5: PC holds the vector right after acknowledge
  a_r5_pc_vector: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> pc_q == VECTOR);
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int          N_REQ    = 4,
  parameter int          W        = 16,
  parameter int          IE_BIT   = 0,
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_INIT  = 16'h0080,
  parameter logic [15:0] VECTOR   = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] irq_req,
  input  logic             instr_done,
  input  logic             reti_req,
  input  logic             core_pc_we,
  input  logic [W-1:0]     core_pc_d,
  input  logic             psr_we,
  input  logic [W-1:0]     psr_d,
  input  logic [W-1:0]     mem_rdata,
  output logic             busy,
  output logic             irq_ack,
  output logic [W-1:0]     pc_q,
  output logic [W-1:0]     sp_q,
  output logic [W-1:0]     psr_q,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  output logic             mem_we,
  output logic             mem_re
);
  logic idle, start_irq, start_ret;
  logic sp_dec, push_pc, push_psr, fin, pop_rd, pop_psr_wb, pop_pc_wb;

  irq_gate #(.N_REQ(N_REQ)) u_gate (
    .irq_req(irq_req), .ie(psr_q[IE_BIT]), .instr_done(instr_done),
    .reti_req(reti_req), .idle(idle),
    .start_irq(start_irq), .start_ret(start_ret)
  );

  irq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_irq(start_irq), .start_ret(start_ret),
    .idle(idle), .sp_dec(sp_dec), .push_pc(push_pc), .push_psr(push_psr),
    .fin(fin), .pop_rd(pop_rd), .pop_psr_wb(pop_psr_wb), .pop_pc_wb(pop_pc_wb)
  );

  irq_regs #(
    .W(W), .IE_BIT(IE_BIT), .PC_RESET(PC_RESET), .SP_INIT(SP_INIT), .VECTOR(VECTOR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .idle(idle), .sp_dec(sp_dec), .push_pc(push_pc),
    .push_psr(push_psr), .fin(fin), .pop_rd(pop_rd), .pop_psr_wb(pop_psr_wb),
    .pop_pc_wb(pop_pc_wb), .core_pc_we(core_pc_we), .core_pc_d(core_pc_d),
    .psr_we(psr_we), .psr_d(psr_d), .mem_rdata(mem_rdata),
    .pc_q(pc_q), .sp_q(sp_q), .psr_q(psr_q), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  assign busy    = !idle;
  assign irq_ack = fin;

  // R6: memory is only touched during a sequence
  a_r6_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);
  // R3: no entry while interrupts are disabled
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !psr_q[IE_BIT] && !reti_req) |=> !busy);
  // R2: no entry without any request
  a_r2_hold_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_req == '0 && !reti_req) |=> !busy);
endmodule

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
  localparam int          N_REQ  = 4;
  localparam logic [15:0] SP0    = 16'h0080;
  localparam logic [15:0] VEC    = 16'h0010;

  logic clk = 0, rst_n = 0;
  logic [N_REQ-1:0] irq_req = '0;
  logic instr_done = 0, reti_req = 0, core_pc_we = 0, psr_we = 0;
  logic [15:0] core_pc_d = '0, psr_d = '0, mem_rdata = '0;
  logic busy, irq_ack, mem_we, mem_re;
  logic [15:0] pc_q, sp_q, psr_q, mem_addr, mem_wdata;

  logic [15:0] bmem [256];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_seq dut (.*);

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  function automatic logic [15:0] exp_ie_off(input logic [15:0] v);
    return {v[15:1], 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pc_psr(input logic [15:0] pc, input logic [15:0] psr);
    core_pc_we = 1; core_pc_d = pc; psr_we = 1; psr_d = psr;
    @(negedge clk);
    core_pc_we = 0; psr_we = 0;
  endtask

  // boundary pulse; returns busy length and ack count
  task automatic boundary(input logic [N_REQ-1:0] req, input bit ret, input bit junk,
                          output int blen, output int acks);
    irq_req = req; reti_req = ret; instr_done = 1;
    @(negedge clk);
    instr_done = 0; reti_req = 0; irq_req = '0;
    blen = 0; acks = 0;
    for (int i = 0; i < 12; i++) begin
      if (!busy) break;
      blen++;
      if (irq_ack) acks++;
      if (junk) begin
        core_pc_we = 1; core_pc_d = 16'($urandom); psr_we = 1; psr_d = 16'($urandom);
      end
      @(negedge clk);
      core_pc_we = 0; psr_we = 0;
    end
  endtask

  task automatic entry_ret(input logic [15:0] pc, input logic [15:0] psr,
                           input logic [N_REQ-1:0] req, input bit junk);
    int bl, ak;
    logic [15:0] sp_b;
    set_pc_psr(pc, psr);
    sp_b = sp_q;
    boundary(req, 0, junk, bl, ak);
    chk(bl == 5, "R6 entry busy length", 16'(bl), 16'd5);
    chk(ak == 1, "R5 ack count", 16'(ak), 16'd1);
    chk(bmem[8'(sp_b - 16'd1)] == pc, "R4 saved PC", bmem[8'(sp_b - 16'd1)], pc);
    chk(bmem[8'(sp_b - 16'd2)] == psr, "R4 saved PSR", bmem[8'(sp_b - 16'd2)], psr);
    chk(sp_q == sp_b - 16'd2, "R4 SP after entry", sp_q, sp_b - 16'd2);
    chk(pc_q == VEC, "R5 PC vector", pc_q, VEC);
    chk(psr_q == exp_ie_off(psr), junk ? "R9 PSR after junk writes" : "R5 PSR IE cleared",
        psr_q, exp_ie_off(psr));
    boundary('0, 1, junk, bl, ak);
    chk(bl == 4, "R6 return busy length", 16'(bl), 16'd4);
    chk(pc_q == pc, "R7 PC restored", pc_q, pc);
    chk(psr_q == psr, "R7 PSR restored", psr_q, psr);
    chk(sp_q == sp_b, "R7 SP restored", sp_q, sp_b);
  endtask

  initial begin
    int bl, ak;
    logic [15:0] rp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    idle_cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pc_q == 16'h0000, "R1 PC reset", pc_q, 16'h0000);
    chk(sp_q == SP0, "R1 SP reset", sp_q, SP0);
    chk(psr_q == 16'h0000, "R1 PSR reset", psr_q, 16'h0000);
    chk(!busy && !irq_ack && !mem_we && !mem_re, "R1 outputs idle",
        {12'd0, busy, irq_ack, mem_we, mem_re}, 16'd0);

    // R3 request with IE clear, and with IE set but no boundary
    boundary(4'b0010, 0, 0, bl, ak);
    chk(bl == 0, "R3 no entry with IE clear", 16'(bl), 16'd0);
    set_pc_psr(16'h1234, 16'h0001);
    irq_req = 4'b0100;
    idle_cyc(3);
    chk(!busy, "R3 no entry without instr_done", {15'd0, busy}, 16'd0);
    irq_req = '0;
    // R2 no request at boundary
    boundary('0, 0, 0, bl, ak);
    chk(bl == 0, "R2 idle without request", 16'(bl), 16'd0);

    // R8 request waits for IE
    set_pc_psr(16'h2000, 16'h0000);
    irq_req = 4'b1000; instr_done = 1;
    idle_cyc(2);
    chk(!busy, "R8 held while IE clear", {15'd0, busy}, 16'd0);
    instr_done = 0;
    psr_we = 1; psr_d = 16'h00A1;
    @(negedge clk);
    psr_we = 0;
    boundary(4'b1000, 0, 0, bl, ak);
    chk(bl == 5, "R8 serviced after IE set", 16'(bl), 16'd5);
    boundary('0, 1, 0, bl, ak);
    chk(psr_q == 16'h00A1, "R8 PSR back after return", psr_q, 16'h00A1);

    // R10 return collides with eligible request
    set_pc_psr(16'h3000, 16'h0005);
    boundary(4'b0001, 0, 0, bl, ak);
    rp = 16'h3000;
    psr_we = 1; psr_d = 16'h0001; // handler enables nesting
    @(negedge clk);
    psr_we = 0;
    boundary(4'b0001, 1, 0, bl, ak);
    chk(bl == 4 && ak == 0, "R10 return wins", 16'(bl), 16'd4);
    chk(pc_q == rp, "R10 PC after return", pc_q, rp);

    // R2 each line alone, R4/R5/R7 random, R9 junk writes during sequences
    for (int k = 0; k < N_REQ; k++)
      entry_ret(16'($urandom), 16'($urandom) | 16'h0001, 4'(1 << k), 0);
    for (int t = 0; t < 40; t++)
      entry_ret(16'($urandom), 16'($urandom) | 16'h0001, 4'($urandom_range(1, 15)), t[0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd1, 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule